// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Timing Controller

This block runs read and write cycles on a 16-bit asynchronous static RAM from a synchronous clock domain. The system side offers one request at a time through a valid/ready handshake: a read or write flag, an address, two byte-lane enables and write data. Reads come back as a one-cycle response pulse with the read word. On the memory side the block drives the address, a low-active and a high-active chip enable, write enable, output enable, two low-active byte strobes and a split data bus with a drive enable.

Every phase length is a whole number of clock cycles. Each length comes from the device's nanosecond limits and a clock-period parameter, so retargeting to a new clock or part means changing parameters only. A write pulse lasts as long as the longest of the pulse-width, address-to-end and data-setup limits. Address and data stay on the pins for at least one cycle after the strobes drop. After every read, the block waits for the output-disable time before it can drive the bus. With no request pending, both chip enables and both byte strobes sit in their inactive state, which places the memory in standby.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held, and whenever `req_ready_o` is high, the memory sits in standby: `sram_ce1_n_o`=1, `sram_ce2_o`=0, `sram_we_n_o`=1, `sram_oe_n_o`=1, `sram_ub_n_o`=`sram_lb_n_o`=1 and `sram_dq_oe_o`=0.
- R2: A read holds `sram_ce1_n_o`=0, `sram_ce2_o`=1 and `sram_oe_n_o`=0 for RD_CYC cycles, with write enable high. It then samples `sram_dq_i` and pulses `rsp_valid_o` for one cycle with that word on `rsp_rdata_o`.
- R3: During a write, `sram_we_n_o`=0, `sram_ce1_n_o`=0 and `sram_ce2_o`=1 together for WP_CYC cycles. Address and data stay constant through the whole window, and the window lasts at least the pulse, address-to-end and data-setup limits.
- R4: A write ends by raising `sram_we_n_o` and `sram_ce1_n_o` and lowering `sram_ce2_o` on one edge. Address and driven data stay unchanged for at least one further cycle. The next address change comes no earlier than the write-cycle limit after the window opened.
- R5: `req_be_i[1]` enables data bits 15:8 through `sram_ub_n_o` (low = enabled), and `req_be_i[0]` enables bits 7:0 through `sram_lb_n_o`. A write changes only the enabled lanes. A read returns zero in the disabled lanes.
- R6: The block never drives the data bus while `sram_oe_n_o` is low. It does not raise `sram_dq_oe_o` until at least the output-disable time has passed since `sram_oe_n_o` rose.
- R7: Each phase length is ceil(limit_ns*1000/CLK_PS), with a minimum of 1. RD_CYC is the largest of the read-cycle, address-access, enable-access and output-enable-access counts. With a 5000 ps clock and the default limits, a response arrives 15 cycles after the request is offered to an idle block.
- R8: A request is taken when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low until the cycle and its recovery have finished. Responses come back in request order, one per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_be_i | input | 2 | Lane enables, bit 1 = bits 15:8, bit 0 = bits 7:0 (nonzero) |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | 16 | Read data, disabled lanes zero |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce1_n_o | output | 1 | Chip enable, active low |
| sram_ce2_o | output | 1 | Chip enable, active high |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_ub_n_o | output | 1 | Upper lane strobe, active low |
| sram_lb_n_o | output | 1 | Lower lane strobe, active low |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 16 | Data from memory |

## Verification
The bench drives a timing-aware memory model. The model returns a poison word if a read is sampled before the address, enable and output-enable access times have all passed, so a phase that is too short appears as a data mismatch rather than a silent pass. The stimulus covers full-word, upper-only and lower-only accesses. Lane mixing shows up as wrong bytes, and stale lanes show up as non-zero bytes on reads.

Back-to-back writes, a write right after a read and a read right after a write exercise the write-window, hold-after-end and turnaround rules. Addresses with high bits set confirm that the full address travels with each cycle.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WR    = 3'd2,
    ST_WTAIL = 3'd3,
    ST_HZ    = 3'd4
  } phase_e;

  function automatic int ns2cyc(int lim_ns, int clk_ps);
    int c;
    c = (lim_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 14,
  parameter int WP_CYC   = 12,
  parameter int TAIL_CYC = 2,
  parameter int HZ_CYC   = 5,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             done_i,
  output phase_e           state_q_o,
  output phase_e           state_d_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o
);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TL_LD = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);

  phase_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (req_we_i) begin
          state_d    = ST_WR;
          load_val_o = WP_LD;
        end else begin
          state_d    = ST_RD;
          load_val_o = RD_LD;
        end
      end
      ST_RD: if (done_i) begin
        state_d    = ST_HZ;
        load_o     = 1'b1;
        load_val_o = HZ_LD;
        capture_o  = 1'b1;
      end
      ST_WR: if (done_i) begin
        state_d    = ST_WTAIL;
        load_o     = 1'b1;
        load_val_o = TL_LD;
      end
      ST_WTAIL: if (done_i) state_d = ST_IDLE;
      ST_HZ:    if (done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/sram_lane_mux.sv
`timescale 1ns/1ps
module sram_lane_mux #(
  parameter int LANES = 2,
  localparam int DW   = LANES * 8
) (
  input  logic [LANES-1:0] strobe_be_i,
  input  logic             active_i,
  input  logic [LANES-1:0] mask_be_i,
  input  logic [DW-1:0]    raw_i,
  output logic [LANES-1:0] be_n_o,
  output logic [DW-1:0]    masked_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n_o[g]        = ~(active_i & strobe_be_i[g]);
    assign masked_o[g*8 +: 8] = mask_be_i[g] ? raw_i[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CLK_PS    = 5000,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_ACE_NS  = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_WP_NS   = 50,
  parameter int T_WC_NS   = 70,
  parameter int T_AW_NS   = 60,
  parameter int T_DW_NS   = 30,
  parameter int T_OHZ_NS  = 25,
  parameter int T_WHZ_NS  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [15:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce1_n_o,
  output logic              sram_ce2_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic              sram_ub_n_o,
  output logic              sram_lb_n_o,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [15:0]       sram_dq_i
);
  localparam int LANES    = 2;
  localparam int RD_CYC   = imax(imax(ns2cyc(T_RC_NS, CLK_PS), ns2cyc(T_AA_NS, CLK_PS)),
                                 imax(ns2cyc(T_ACE_NS, CLK_PS), ns2cyc(T_OE_NS, CLK_PS)));
  localparam int WP_CYC   = imax(ns2cyc(T_WP_NS, CLK_PS),
                                 imax(ns2cyc(T_AW_NS, CLK_PS), ns2cyc(T_DW_NS, CLK_PS)));
  localparam int TAIL_CYC = imax(1, ns2cyc(T_WC_NS, CLK_PS) - WP_CYC);
  localparam int HZ_CYC   = imax(ns2cyc(T_OHZ_NS, CLK_PS), ns2cyc(T_WHZ_NS, CLK_PS));
  localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(TAIL_CYC, HZ_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  phase_e           state_q, state_d;
  logic             load, done, accept, capture;
  logic [CNT_W-1:0] load_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .done_o(done)
  );

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TAIL_CYC(TAIL_CYC), .HZ_CYC(HZ_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .done_i(done),
    .state_q_o(state_q), .state_d_o(state_d), .load_o(load), .load_val_o(load_val),
    .accept_o(accept), .capture_o(capture)
  );

  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q, rdata_q, rd_masked;
  logic [LANES-1:0]  be_q, be_nxt, be_n_d, be_n_q;
  logic              ce1_n_q, ce2_q, we_n_q, oe_n_q, dq_oe_q, rsp_q;
  logic              rd_nxt, wr_nxt, act_nxt;

  // strobes are registered from the next phase so no decode glitch reaches the pins
  assign rd_nxt  = (state_d == ST_RD);
  assign wr_nxt  = (state_d == ST_WR);
  assign act_nxt = rd_nxt | wr_nxt;
  assign be_nxt  = accept ? req_be_i : be_q;

  sram_lane_mux #(.LANES(LANES)) u_lanes (
    .strobe_be_i(be_nxt), .active_i(act_nxt), .mask_be_i(be_q), .raw_i(sram_dq_i),
    .be_n_o(be_n_d), .masked_o(rd_masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce1_n_q <= 1'b1;
      ce2_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      be_n_q  <= '1;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      ce1_n_q <= ~act_nxt;
      ce2_q   <= act_nxt;
      we_n_q  <= ~wr_nxt;
      oe_n_q  <= ~rd_nxt;
      dq_oe_q <= wr_nxt | (state_d == ST_WTAIL);
      be_n_q  <= be_n_d;
      rsp_q   <= capture;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      if (capture) rdata_q <= rd_masked;
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = rsp_q;
  assign rsp_rdata_o  = rdata_q;
  assign sram_addr_o  = addr_q;
  assign sram_ce1_n_o = ce1_n_q;
  assign sram_ce2_o   = ce2_q;
  assign sram_we_n_o  = we_n_q;
  assign sram_oe_n_o  = oe_n_q;
  assign sram_ub_n_o  = be_n_q[1];
  assign sram_lb_n_o  = be_n_q[0];
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int CLK_PS  = 5000,
  parameter int T_WP_NS = 50,
  parameter int T_AW_NS = 60,
  parameter int T_DW_NS = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce1_n_o,
  input logic              sram_ce2_o,
  input logic              sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic              sram_ub_n_o,
  input logic              sram_lb_n_o,
  input logic [15:0]       sram_dq_o,
  input logic              sram_dq_oe_o
);
  localparam int WP_MIN = imax(ns2cyc(T_WP_NS, CLK_PS),
                               imax(ns2cyc(T_AW_NS, CLK_PS), ns2cyc(T_DW_NS, CLK_PS)));

  logic     win;
  logic [7:0] win_cnt;
  assign win = ~sram_we_n_o & ~sram_ce1_n_o & sram_ce2_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            win_cnt <= '0;
    else if (!win)          win_cnt <= '0;
    else if (win_cnt != '1) win_cnt <= win_cnt + 1'b1;
  end

  a_r1_idle_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce1_n_o && !sram_ce2_o && sram_we_n_o && sram_oe_n_o
                     && sram_ub_n_o && sram_lb_n_o && !sram_dq_oe_o));

  a_r2_read_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> (sram_we_n_o && !sram_ce1_n_o && sram_ce2_o));

  a_r3_window_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && $past(win)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o) && sram_dq_oe_o));

  a_r3_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win && $past(win)) |-> (int'(win_cnt) >= WP_MIN || win_cnt == '0 && $past(win_cnt) >= 8'(WP_MIN - 1)));

  a_r4_end_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win && $past(win)) |-> (sram_we_n_o && sram_ce1_n_o && !sram_ce2_o));

  a_r4_tail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win && $past(win)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o) && sram_dq_oe_o));

  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> !sram_dq_oe_o);

  a_r8_busy_on_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  a_r5_lane_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win |-> !(sram_ub_n_o && sram_lb_n_o));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .T_WP_NS(T_WP_NS), .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS)
) u_chk (.*);

// File: tb/sram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb;
  localparam int AW     = 18;
  localparam int CLK_PS = 5000;
  localparam int RD_EXP = (70 * 1000 + CLK_PS - 1) / CLK_PS;  // R7: 14 cycles at 5 ns

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = 2'b11;
  logic [15:0]   req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] s_addr;
  logic          s_ce1_n, s_ce2, s_we_n, s_oe_n, s_ub_n, s_lb_n, s_dq_oe;
  logic [15:0]   s_dq_o;
  logic [15:0]   s_dq_i = 16'hDEAD;

  sram_cycle_ctrl #(.ADDR_W(AW), .CLK_PS(CLK_PS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sram_addr_o(s_addr),
    .sram_ce1_n_o(s_ce1_n), .sram_ce2_o(s_ce2), .sram_we_n_o(s_we_n), .sram_oe_n_o(s_oe_n),
    .sram_ub_n_o(s_ub_n), .sram_lb_n_o(s_lb_n), .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe),
    .sram_dq_i(s_dq_i)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // timing-aware memory model, evaluated half a cycle after each DUT edge
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  initial for (int i = 0; i < 256; i++) begin
    mem[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
    shadow[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
  end

  int cyc = 0, t_addr = 0, t_en = 0, t_oe_fall = 0, t_oe_rise = -100, ws = 0, last_ws = 0;
  bit pend_wc = 1'b0, p_win = 1'b0, p_ce = 1'b0, p_oe_n = 1'b1, p_ub = 1'b1, p_lb = 1'b1, p_dqoe = 1'b0;
  logic [AW-1:0] p_addr = '0, w_addr = '0;
  logic [15:0]   p_dq = '0, w_data = '0;
  bit w_ub = 1'b1, w_lb = 1'b1, ce_on = 1'b0, win = 1'b0;

  always @(negedge clk) begin
    cyc++;
    ce_on = !s_ce1_n && s_ce2;
    win   = ce_on && !s_we_n;
    if (rst_n) begin
      if (s_addr != p_addr) begin
        t_addr = cyc;
        if (p_win && win) check(1'b0, "R3", "address moved inside write window", int'(s_addr), int'(p_addr));
        if (pend_wc) begin
          check((cyc - last_ws) * 5 >= 70, "R4", "write cycle ns", (cyc - last_ws) * 5, 70);
          pend_wc = 1'b0;
        end
      end
      if ((ce_on && !p_ce) || s_ub_n != p_ub || s_lb_n != p_lb) t_en = cyc;
      if (!s_oe_n && p_oe_n) t_oe_fall = cyc;
      if (s_oe_n && !p_oe_n) t_oe_rise = cyc;
      if (s_dq_oe && !p_dqoe)
        check((cyc - t_oe_rise) * 5 >= 25, "R6", "bus driven too soon after output disable",
              (cyc - t_oe_rise) * 5, 25);
      if (win && p_win && s_dq_o != p_dq)
        check(1'b0, "R3", "data moved inside write window", int'(s_dq_o), int'(p_dq));
      if (win && !p_win) begin
        ws = cyc; w_addr = s_addr; w_data = s_dq_o; w_ub = s_ub_n; w_lb = s_lb_n;
      end
      if (!win && p_win) begin
        check((cyc - ws) * 5 >= 60, "R3", "write window ns", (cyc - ws) * 5, 60);
        check(s_addr == w_addr && s_dq_o == w_data && s_dq_oe, "R4", "hold after write end",
              int'(s_dq_o), int'(w_data));
        if (!w_lb) mem[w_addr[7:0]][7:0]  = w_data[7:0];
        if (!w_ub) mem[w_addr[7:0]][15:8] = w_data[15:8];
        last_ws = ws; pend_wc = 1'b1;
      end
      if (ce_on && !s_oe_n && s_we_n) begin
        if (s_dq_oe) check(1'b0, "R6", "bus contention", 1, 0);
        if ((cyc - t_addr + 1) * 5 >= 70 && (cyc - t_en + 1) * 5 >= 70 && (cyc - t_oe_fall + 1) * 5 >= 35)
          s_dq_i = {s_ub_n ? 8'hEE : mem[s_addr[7:0]][15:8], s_lb_n ? 8'hEE : mem[s_addr[7:0]][7:0]};
        else
          s_dq_i = 16'hDEAD;
      end else begin
        s_dq_i = 16'hDEAD;
      end
    end else begin
      t_addr = cyc; t_en = cyc; t_oe_fall = cyc;
    end
    p_win = win; p_ce = ce_on; p_oe_n = s_oe_n; p_ub = s_ub_n; p_lb = s_lb_n;
    p_dqoe = s_dq_oe; p_addr = s_addr; p_dq = s_dq_o;
  end

  // scoreboard
  logic [15:0] exp_q [$];
  time         exp_t [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "response without request", int'(rsp_rdata), 0);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic time t0 = exp_t.pop_front();
        check(rsp_rdata == e, "R2", "read data", int'(rsp_rdata), int'(e));
        check((($time - t0) / 5) == RD_EXP + 1, "R7", "read latency cycles",
              int'(($time - t0) / 5), RD_EXP + 1);
      end
    end
  end

  task automatic do_op(bit we, logic [AW-1:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
    if (we) begin
      if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
    end else begin
      exp_q.push_back({be[1] ? shadow[a[7:0]][15:8] : 8'h00, be[0] ? shadow[a[7:0]][7:0] : 8'h00});
      exp_t.push_back($time);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8", "ready low after accept", int'(req_ready), 0);
  endtask

  task automatic check_standby(string what);
    check(s_ce1_n && !s_ce2, "R1", {what, " chip enables"}, int'({s_ce1_n, s_ce2}), 2);
    check(s_we_n && s_oe_n, "R1", {what, " we/oe"}, int'({s_we_n, s_oe_n}), 3);
    check(s_ub_n && s_lb_n, "R1", {what, " lane strobes"}, int'({s_ub_n, s_lb_n}), 3);
    check(!s_dq_oe, "R1", {what, " bus released"}, int'(s_dq_oe), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_standby("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_standby("after reset");
    check(req_ready, "R8", "ready after reset", int'(req_ready), 1);
    // R2/R5: full word and single-lane reads of initial content
    do_op(1'b0, 18'h00010, 2'b11, '0);
    do_op(1'b0, 18'h00011, 2'b10, '0);
    do_op(1'b0, 18'h00012, 2'b01, '0);
    // R3/R4/R5: back-to-back writes, word and single lanes
    do_op(1'b1, 18'h20020, 2'b11, 16'hC0DE);
    do_op(1'b1, 18'h3FF21, 2'b10, 16'hAB00);
    do_op(1'b1, 18'h00022, 2'b01, 16'h00CD);
    // read after write, then write after read (R6 turnaround)
    do_op(1'b0, 18'h20020, 2'b11, '0);
    do_op(1'b1, 18'h00030, 2'b11, 16'h1234);
    do_op(1'b0, 18'h3FF21, 2'b11, '0);
    do_op(1'b0, 18'h00022, 2'b11, '0);
    do_op(1'b0, 18'h00030, 2'b10, '0);
    do_op(1'b1, 18'h00030, 2'b01, 16'hFF99);
    do_op(1'b0, 18'h00030, 2'b11, '0);
    do_op(1'b0, 18'h000FF, 2'b11, '0);
    repeat (40) @(negedge clk);
    check_standby("idle");
    check(exp_q.size() == 0, "R8", "responses outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule